// File: doc/BRIEF.md
# Sticky Fault Diagnosis Word for an H-Bridge Driver

This block gathers the fault and status event flags of a motor H-bridge into one 16-bit diagnosis word. Most flags are sticky: once an event is seen, its bit stays at 1 until a release event. The undervoltage flag of the battery supply and the bridge-active flag are live and follow their sources. From the word the block derives a request to float the bridge outputs whenever a critical fault is held or the bridge is not enabled.

Three events release the sticky bits. The first is a power-on (synchronous) reset. The second is a rising edge of the bridge-active signal after synchronization, meaning the bridge went from disabled to enabled. The third is a diagnosis read over the serial port. A mode bit makes the critical faults survive a read, so the bridge stays floated until the enable is toggled. In that mode the critical faults are supply overvoltage, thermal shutdown and the four switch overcurrents. The thermal-warning bit is set only while the die is hot and current limiting is active together. Because a present event always wins over a clear, that bit cannot be released while both conditions still hold.

Top module: `hb_fault_diag`

## Requirements
- R1: Bit positions in `diag_word` are: 0 off-state open load, 1 on-state open load, 2 battery undervoltage, 3 logic-supply overvoltage, 4 current limit reached, 5 thermal warning, 6 thermal shutdown, 7 bridge active, 8 low-side 1 overcurrent, 9 low-side 2 overcurrent, 10 high-side 1 overcurrent, 11 high-side 2 overcurrent, 14 short to ground while off, 15 short to battery while off.
- R2: After reset `diag_word` reads 16'h0080 (bridge-active 1, all else 0) and `tristate_req` is 0.
- R3: Bit 2 is live. It equals `ev_vs_uv` in the same cycle and is never held.
- R4: Bit 7 is live. It equals `act_in` delayed by SYNC_STAGES (default 2) clock edges.
- R5: Each latched bit (0,1,3,4,5,6,8–11,14,15) goes to 1 at the edge after its event is sampled. It stays 1 until a release.
- R6: With `cfg_keep_crit`=0, a cycle with `rd_strobe`=1 clears every latched bit at that edge.
- R7: With `cfg_keep_crit`=1, a read clears only the non-critical latched bits (0,1,4,5,14,15). Bits 3,6,8–11 keep their value.
- R8: A rising edge of the synchronized bridge-active signal clears every latched bit, whatever the mode. The clear takes effect SYNC_STAGES+1 edges after `act_in` rises.
- R9: An event sampled in the same cycle as a clear wins, and its bit stays 1.
- R10: Bit 5 is set only when `ev_temp_hi` and `ev_ilim` are both 1. A clear releases it only when they are not both 1.
- R11: `ev_ol_on` sets bit 1 only while `cfg_olon_en`=1.
- R12: `tristate_req` is 1 exactly when any of bits 2,3,6,8–11 is 1 or bit 7 is 0.
- R13: Bits 12 and 13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| act_in | input | 1 | Raw bridge-active status (enable pins resolved) |
| cfg_keep_crit | input | 1 | 1: critical faults survive a read |
| cfg_olon_en | input | 1 | Enables on-state open-load capture |
| rd_strobe | input | 1 | One-cycle pulse when the word is read |
| ev_ol_off | input | 1 | Open load seen in off state |
| ev_ol_on | input | 1 | Open load seen in on state |
| ev_vs_uv | input | 1 | Battery supply undervoltage (live) |
| ev_vdd_ov | input | 1 | Logic supply overvoltage |
| ev_ilim | input | 1 | Current limiting active |
| ev_temp_hi | input | 1 | Die above warning temperature |
| ev_tsd | input | 1 | Thermal shutdown |
| ev_oc | input | 4 | Overcurrent: [0] low 1, [1] low 2, [2] high 1, [3] high 2 |
| ev_sgnd_off | input | 1 | Short to ground in off state |
| ev_sbat_off | input | 1 | Short to battery in off state |
| diag_word | output | 16 | Diagnosis word |
| tristate_req | output | 1 | Request to float the bridge outputs |

## Verification
A release and a new event can land on the same edge. This happens through a read or an enable edge, with the event flag of the same bit held high. The bench provokes it on purpose for open load and for the thermal warning, and the held event must leave the bit at 1. A read and an enable edge can also coincide with the keep mode set. That case is reached in the random phase, where the read strobe and the enable toggling are drawn independently. Every cycle is compared against a bench model built from the release rules, and in that model the enable edge must clear the critical bits that the read leaves alone.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int DIAG_W = 16;

    localparam int BIT_OL_OFF  = 0;
    localparam int BIT_OL_ON   = 1;
    localparam int BIT_VS_UV   = 2;
    localparam int BIT_VDD_OV  = 3;
    localparam int BIT_ILIM    = 4;
    localparam int BIT_TWARN   = 5;
    localparam int BIT_TSD     = 6;
    localparam int BIT_ACT     = 7;
    localparam int BIT_OC_LO   = 8;
    localparam int BIT_SGND    = 14;
    localparam int BIT_SBAT    = 15;

    // bits held until a release
    localparam logic [DIAG_W-1:0] LATCH_MASK = 16'hCF7B;
    // bits that a read does not release in keep mode
    localparam logic [DIAG_W-1:0] KEEP_MASK  = 16'h0F48;
    // live or latched bits that float the bridge when 1
    localparam logic [DIAG_W-1:0] TRI_MASK   = 16'h0F4C;

    typedef struct packed {
        logic       ol_off;
        logic       ol_on;
        logic       vs_uv;
        logic       vdd_ov;
        logic       ilim;
        logic       temp_hi;
        logic       tsd;
        logic [3:0] oc;
        logic       sgnd_off;
        logic       sbat_off;
    } hbd_evt_t;

    function automatic logic [DIAG_W-1:0] build_set(hbd_evt_t e, logic olon_en, logic act);
        logic [DIAG_W-1:0] v;
        v = '0;
        v[BIT_OL_OFF]            = e.ol_off;
        v[BIT_OL_ON]             = e.ol_on & olon_en;
        v[BIT_VS_UV]             = e.vs_uv;
        v[BIT_VDD_OV]            = e.vdd_ov;
        v[BIT_ILIM]              = e.ilim;
        v[BIT_TWARN]             = e.temp_hi & e.ilim;
        v[BIT_TSD]               = e.tsd;
        v[BIT_ACT]               = act;
        v[BIT_OC_LO +: 4]        = e.oc;
        v[BIT_SGND]              = e.sgnd_off;
        v[BIT_SBAT]              = e.sbat_off;
        return v;
    endfunction

endpackage

// File: rtl/hbd_act_sync.sv
module hbd_act_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic act_raw,
    output logic act_sync,
    output logic act_rise
);
    logic [STAGES-1:0] chain;
    logic              act_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= act_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], act_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) act_prev <= 1'b1;
        else     act_prev <= chain[STAGES-1];
    end

    assign act_sync = chain[STAGES-1];
    assign act_rise = chain[STAGES-1] & ~act_prev;
endmodule

// File: rtl/hbd_latch_bank.sv
module hbd_latch_bank #(
    parameter int              W     = 16,
    parameter logic [W-1:0]    LMASK = '1,
    parameter logic [W-1:0]    KMASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         rd_clr,
    input  logic         en_clr,
    input  logic         keep_mode,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (LMASK[i]) begin : g_sticky
                logic held;
                logic clr;
                assign clr = en_clr | (rd_clr & ~(keep_mode & KMASK[i]));
                always_ff @(posedge clk) begin
                    if (rst) held <= 1'b0;
                    else     held <= set_vec[i] | (held & ~clr);
                end
                assign q[i] = held;
            end else begin : g_live
                assign q[i] = set_vec[i];
            end
        end
    endgenerate
endmodule

// File: rtl/hb_fault_diag.sv
module hb_fault_diag
    import hbd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        act_in,
    input  logic        cfg_keep_crit,
    input  logic        cfg_olon_en,
    input  logic        rd_strobe,
    input  logic        ev_ol_off,
    input  logic        ev_ol_on,
    input  logic        ev_vs_uv,
    input  logic        ev_vdd_ov,
    input  logic        ev_ilim,
    input  logic        ev_temp_hi,
    input  logic        ev_tsd,
    input  logic [3:0]  ev_oc,
    input  logic        ev_sgnd_off,
    input  logic        ev_sbat_off,
    output logic [15:0] diag_word,
    output logic        tristate_req
);
    hbd_evt_t          evt;
    logic              act_sync;
    logic              act_rise;
    logic [DIAG_W-1:0] set_vec;

    always_comb begin
        evt.ol_off   = ev_ol_off;
        evt.ol_on    = ev_ol_on;
        evt.vs_uv    = ev_vs_uv;
        evt.vdd_ov   = ev_vdd_ov;
        evt.ilim     = ev_ilim;
        evt.temp_hi  = ev_temp_hi;
        evt.tsd      = ev_tsd;
        evt.oc       = ev_oc;
        evt.sgnd_off = ev_sgnd_off;
        evt.sbat_off = ev_sbat_off;
    end

    hbd_act_sync #(.STAGES(SYNC_STAGES)) act_sync_i (
        .clk      (clk),
        .rst      (rst),
        .act_raw  (act_in),
        .act_sync (act_sync),
        .act_rise (act_rise)
    );

    assign set_vec = build_set(evt, cfg_olon_en, act_sync);

    hbd_latch_bank #(
        .W     (DIAG_W),
        .LMASK (LATCH_MASK),
        .KMASK (KEEP_MASK)
    ) bank_i (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .rd_clr    (rd_strobe),
        .en_clr    (act_rise),
        .keep_mode (cfg_keep_crit),
        .q         (diag_word)
    );

    assign tristate_req = (|(diag_word & TRI_MASK)) | ~diag_word[BIT_ACT];
endmodule

// File: rtl/hb_fault_diag_chk.sv
module hb_fault_diag_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_strobe,
    input logic        cfg_keep_crit,
    input logic        cfg_olon_en,
    input logic        ev_ol_off,
    input logic        ev_vs_uv,
    input logic        ev_ilim,
    input logic        ev_temp_hi,
    input logic        act_rise,
    input logic [15:0] diag_word,
    input logic        tristate_req
);
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        diag_word[13:12] == 2'b00);                                        // R13

    AST_INACTIVE_FLOATS: assert property (@(posedge clk) disable iff (rst)
        !diag_word[7] |-> tristate_req);                                   // R12

    AST_UNDERVOLT_FLOATS: assert property (@(posedge clk) disable iff (rst)
        ev_vs_uv |-> tristate_req);                                        // R12

    AST_KEEP_OVERVOLT: assert property (@(posedge clk) disable iff (rst)
        (diag_word[3] && !act_rise && (cfg_keep_crit || !rd_strobe))
        |=> diag_word[3]);                                                 // R7

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !ev_ol_off) |=> !diag_word[0]);                      // R6

    AST_ENABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (act_rise && !ev_ol_off) |=> !diag_word[0]);                       // R8

    AST_TWARN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (!diag_word[5] && !(ev_temp_hi && ev_ilim)) |=> !diag_word[5]);    // R10

    AST_OLON_GATED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_olon_en && !diag_word[1]) |=> !diag_word[1]);                // R11
endmodule

bind hb_fault_diag hb_fault_diag_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .rd_strobe     (rd_strobe),
    .cfg_keep_crit (cfg_keep_crit),
    .cfg_olon_en   (cfg_olon_en),
    .ev_ol_off     (ev_ol_off),
    .ev_vs_uv      (ev_vs_uv),
    .ev_ilim       (ev_ilim),
    .ev_temp_hi    (ev_temp_hi),
    .act_rise      (act_rise),
    .diag_word     (diag_word),
    .tristate_req  (tristate_req)
);

// File: tb/hb_fault_diag_tb_top.sv
module hb_fault_diag_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        act_in = 1'b1;
    logic        keep = 1'b0;
    logic        olon = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] ev = '0;   // indexed by word position, bit5 = temp_hi
    logic [15:0] diag_word;
    logic        tristate_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hb_fault_diag dut_i (
        .clk(clk), .rst(rst), .act_in(act_in),
        .cfg_keep_crit(keep), .cfg_olon_en(olon), .rd_strobe(rd),
        .ev_ol_off(ev[0]), .ev_ol_on(ev[1]), .ev_vs_uv(ev[2]),
        .ev_vdd_ov(ev[3]), .ev_ilim(ev[4]), .ev_temp_hi(ev[5]),
        .ev_tsd(ev[6]), .ev_oc(ev[11:8]),
        .ev_sgnd_off(ev[14]), .ev_sbat_off(ev[15]),
        .diag_word(diag_word), .tristate_req(tristate_req)
    );

    // bench model built from the requirement text
    localparam logic [15:0] M_LATCHED = 16'hCF7B;
    localparam logic [15:0] M_KEEP    = 16'h0F48;
    logic [15:0] m_lat;
    logic [1:0]  m_sh;
    logic        m_prev;

    function automatic logic [15:0] m_word(logic [15:0] lat, logic act, logic uv);
        logic [15:0] w;
        w = lat;
        w[2] = uv;
        w[7] = act;
        return w;
    endfunction

    function automatic logic m_tri(logic [15:0] w);
        return w[2] | w[3] | w[6] | (|w[11:8]) | !w[7];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lat  = '0;
            m_sh   = 2'b11;
            m_prev = 1'b1;
        end else begin
            logic        rise;
            logic [15:0] setv;
            rise = m_sh[1] & ~m_prev;
            setv = ev & M_LATCHED;
            setv[1] = ev[1] & olon;
            setv[5] = ev[5] & ev[4];
            for (int i = 0; i < 16; i++) begin
                if (M_LATCHED[i]) begin
                    logic clr;
                    clr = rise | (rd & !(keep & M_KEEP[i]));
                    m_lat[i] = setv[i] | (m_lat[i] & !clr);
                end
            end
            m_prev = m_sh[1];
            m_sh   = {m_sh[0], act_in};
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_clear();
        rd = 1'b1; tick(1); rd = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R2 reset word", diag_word, 16'h0080);
        chk("R2 reset tristate", tristate_req, 1'b0);

        // R1 positions of latched bits
        olon = 1'b1;
        foreach (M_LATCHED[p]) begin
            if (M_LATCHED[p] && p != 5) begin
                ev[p] = 1'b1; tick(1); ev = '0;
                chk($sformatf("R1 bit %0d", p), diag_word, (32'h1 << p) | 32'h80);
                read_clear();
            end
        end

        // R5 sticky and R12 tristate
        ev[10] = 1'b1; tick(1); ev = '0; tick(5);
        chk("R5 sticky oc", diag_word[10], 1'b1);
        chk("R12 tristate on oc", tristate_req, 1'b1);

        // R7 keep mode: read frees non-critical only
        keep = 1'b1;
        ev[0] = 1'b1; tick(1); ev = '0;
        read_clear();
        chk("R7 keep crit", diag_word, 16'h0480);
        // R6 normal mode read frees all
        keep = 1'b0;
        read_clear();
        chk("R6 read clears", diag_word, 16'h0080);
        chk("R12 tristate released", tristate_req, 1'b0);

        // R9 event at clear wins
        ev[0] = 1'b1; tick(1);
        rd = 1'b1; tick(1); rd = 1'b0; ev = '0;
        chk("R9 event beats read", diag_word[0], 1'b1);
        read_clear();
        chk("R9 later read frees", diag_word[0], 1'b0);

        // R10 thermal warning
        ev[5] = 1'b1; tick(2);
        chk("R10 hot alone", diag_word[5], 1'b0);
        ev[4] = 1'b1; tick(1);
        chk("R10 hot and limiting", diag_word[5], 1'b1);
        read_clear();
        chk("R10 no release while both", diag_word[5], 1'b1);
        ev[4] = 1'b0;
        read_clear();
        chk("R10 release after condition gone", diag_word[5], 1'b0);
        ev = '0;

        // R11 on-state open load gate
        olon = 1'b0;
        ev[1] = 1'b1; tick(2); ev = '0;
        chk("R11 gated off", diag_word[1], 1'b0);
        olon = 1'b1;

        // R3 live undervoltage
        ev[2] = 1'b1; #5;
        chk("R3 live set", diag_word[2], 1'b1);
        chk("R12 tristate on uv", tristate_req, 1'b1);
        tick(1); ev[2] = 1'b0; #5;
        chk("R3 live clear", diag_word[2], 1'b0);

        // R4 and R8 enable path
        keep = 1'b1;
        ev[8] = 1'b1; tick(1); ev = '0;
        act_in = 1'b0; tick(1);
        chk("R4 act not yet", diag_word[7], 1'b1);
        tick(1);
        chk("R4 act low", diag_word[7], 1'b0);
        read_clear();
        chk("R7 oc kept in keep mode", diag_word[8], 1'b1);
        act_in = 1'b1; tick(2);
        chk("R4 act high", diag_word[7], 1'b1);
        chk("R8 not yet released", diag_word[8], 1'b1);
        tick(1);
        chk("R8 enable edge releases", diag_word[8], 1'b0);
        chk("R12 tristate off after enable", tristate_req, 1'b0);
        keep = 1'b0;

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            logic [15:0] r;
            chk("R5 R6 R7 R8 R9 random word", diag_word, m_word(m_lat, m_sh[1], ev[2]));
            chk("R12 random tristate", tristate_req, m_tri(m_word(m_lat, m_sh[1], ev[2])));
            chk("R13 unused zero", diag_word[13:12], 2'b00);
            r = '0;
            for (int b = 0; b < 16; b++) r[b] = ($urandom % 12) == 0;
            r[5] = ($urandom % 3) == 0;
            r[4] = ($urandom % 3) == 0;
            ev   = r;
            rd   = ($urandom % 5) == 0;
            keep = ($urandom % 2) == 0;
            olon = ($urandom % 2) == 0;
            if (($urandom % 15) == 0) act_in = ~act_in;
            tick(1);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule